// File: doc/BRIEF.md
# Sub-pixel programmable clock edge generator

This block produces the fast timing waveforms for a CCD readout: the horizontal clock pair (H1/H3 and its complement H2/H4), the reset-gate clock, the last-stage horizontal clock, and two single-cycle sample strobes. Each strobe marks one sampling point of a correlated double sampler, one for the reset level and one for the data level. The block runs on a fast clock at 48 times the pixel rate. A position counter splits every pixel period into 48 slots, so any programmed edge can be placed at one 48th of a pixel.

Each edge or sample location arrives as a 6-bit code. Bits [5:4] choose a group of 12 slots and bits [3:0] give an offset inside that group. The three clock channels each take a rising-edge code, a falling-edge code and an inversion bit. A horizontal-blanking input forces the H clocks to a chosen level. The position counter has two states. In `ST_IDLE` it waits after reset, with every edge and strobe disabled. The first rising edge of the pixel reference moves it to `ST_RUN` (transition IDLE→RUN), and each later rising edge restarts the count (RUN→RUN resync). Each clock channel is a two-state machine, `LV_LOW` and `LV_HIGH`: a rising-code match moves LOW→HIGH and a falling-code match moves HIGH→LOW. Each strobe is a two-state machine, `SS_WAIT` and `SS_FIRE`: WAIT→FIRE on a location match, and FIRE→WAIT on the next cycle in every case.

Timing reference: E0 is the fast-clock edge at which `pix_ref` is sampled high after being sampled low. An event programmed at slot p is seen at the outputs after clock edge E0+p+1, and again 48 edges later in each later period.

Top module: `subpixel_edge_gen`

## Requirements
- R1: After reset and before the first reference rising edge, the block is idle. All channel levels are low, so each clock output equals its inversion bit, `h24_out` is the inverse of `h13_out`, and neither strobe pulses, whatever codes are applied.
- R2: The slot counter advances by one per fast clock and wraps from 47 back to 0. An edge at slot 47 appears after E0+48, and an edge at slot 0 of the next period appears after E0+49.
- R3: A code maps to slot = code[5:4]×12 + code[3:0]. For example, code 37 maps to slot 29 and code 51 maps to slot 39.
- R4: A code whose bits [3:0] are 12 to 15 never matches a slot, so the edge it describes never occurs and the output keeps its level.
- R5: A rising-code match sets the channel level high after edge E0+p+1.
- R6: A falling-code match sets the channel level low after edge E0+p+1.
- R7: When the rising and falling codes name the same slot, the channel keeps its previous level.
- R8: When a channel's inversion bit is 1, its output is the inverse of its internal level.
- R9: `h24_out` is always the logical inverse of `h13_out`.
- R10: While `hblank` is 1, `h13_out` equals `hblank_level` (so H2/H4 take the opposite level) regardless of the programmed edges. When `hblank` returns to 0, `h13_out` follows the channel again.
- R11: Each of `shp_strobe` and `shd_strobe` is high for exactly one fast-clock cycle per pixel period, after edge E0+p+1 for its decoded slot p.
- R12: A reference rising edge in the middle of a period restarts the counter at slot 0 at that edge. Later events follow the new E0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 48 × pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ref | input | 1 | Pixel reference; a rising edge restarts the slot count |
| rg_rise_code | input | 6 | Reset-gate rising-edge code |
| rg_fall_code | input | 6 | Reset-gate falling-edge code |
| rg_invert | input | 1 | Reset-gate output inversion |
| hl_rise_code | input | 6 | HL clock rising-edge code |
| hl_fall_code | input | 6 | HL clock falling-edge code |
| hl_invert | input | 1 | HL clock output inversion |
| h_rise_code | input | 6 | H1/H3 rising-edge code |
| h_fall_code | input | 6 | H1/H3 falling-edge code |
| h_invert | input | 1 | H1/H3 output inversion |
| shp_code | input | 6 | Reset-level sample location code |
| shd_code | input | 6 | Data-level sample location code |
| hblank | input | 1 | Horizontal blanking active |
| hblank_level | input | 1 | Level of H1/H3 during blanking |
| rg_out | output | 1 | Reset-gate clock |
| hl_out | output | 1 | HL clock |
| h13_out | output | 1 | H1/H3 clock |
| h24_out | output | 1 | H2/H4 clock, the inverse of H1/H3 |
| shp_strobe | output | 1 | Reset-level sample strobe |
| shd_strobe | output | 1 | Data-level sample strobe |

## Verification
Two cases are hard to reach from the ports: the slot-47 to slot-0 wrap, and a reference edge arriving mid-period. Neither shows up unless the bench tracks the exact edge count from E0. The bench therefore aligns every scenario to a one-cycle reference pulse and steps a slot offset one edge at a time. It programs edges at slot 47 and slot 0 so the wrap appears as a one-cycle pulse after E0+48. It then issues a second reference pulse at offset 20 and checks that the programmed edges follow the new origin. Held-level cases (equal slots, invalid offsets) are observed by sampling the output across a whole period or more. Before these observations, the bench first drives the channel to the opposite level with valid codes.

// File: rtl/edge_gen_pkg.sv
package edge_gen_pkg;

    // Slot counter states
    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } cnt_state_t;

    // Clock channel level states
    typedef enum logic {
        LV_LOW,
        LV_HIGH
    } level_state_t;

    // Sample strobe states
    typedef enum logic {
        SS_WAIT,
        SS_FIRE
    } strobe_state_t;

endpackage

// File: rtl/edge_code_decode.sv
module edge_code_decode #(
    parameter int unsigned CODE_W    = 6,
    parameter int unsigned POS_W     = 6,
    parameter int unsigned QUAD_STEP = 12
) (
    input  logic [CODE_W-1:0] code,
    output logic              valid,
    output logic [POS_W-1:0]  pos
);
    localparam int unsigned OFF_W = CODE_W - 2;

    logic [1:0]       quad;
    logic [OFF_W-1:0] offset;

    assign quad   = code[CODE_W-1 -: 2];
    assign offset = code[OFF_W-1:0];

    always_comb begin
        valid = (int'(offset) < int'(QUAD_STEP));
        pos   = POS_W'(int'(quad) * int'(QUAD_STEP) + int'(offset));
    end

endmodule

// File: rtl/pixel_pos_counter.sv
module pixel_pos_counter
    import edge_gen_pkg::*;
#(
    parameter int unsigned POSITIONS = 48,
    parameter int unsigned POS_W     = $clog2(POSITIONS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_ref,
    output logic [POS_W-1:0] pos,
    output logic             running
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(POSITIONS - 1);

    cnt_state_t       state_q, state_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic             ref_q;
    logic             ref_rise;

    assign ref_rise = pix_ref && !ref_q;

    // State and count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            ref_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            ref_q   <= pix_ref;
        end
    end

    // Next state and count
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_rise) begin
                    state_d = ST_RUN;
                    pos_d   = '0;
                end
            end
            ST_RUN: begin
                if (ref_rise) begin
                    pos_d = '0;
                end else if (pos_q == LAST_POS) begin
                    pos_d = '0;
                end else begin
                    pos_d = pos_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        pos     = pos_q;
        running = (state_q == ST_RUN);
    end

    AST_SYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ref_rise |=> (pos == '0) && running); // R12
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pos == LAST_POS && !ref_rise) |=> (pos == '0)); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pos != LAST_POS && !ref_rise) |=> (pos == $past(pos) + 1'b1)); // R2
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ref_rise) |=> !running); // R1

endmodule

// File: rtl/edge_channel.sv
module edge_channel
    import edge_gen_pkg::*;
#(
    parameter int unsigned POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [POS_W-1:0] pos,
    input  logic             rise_valid,
    input  logic [POS_W-1:0] rise_pos,
    input  logic             fall_valid,
    input  logic [POS_W-1:0] fall_pos,
    input  logic             invert,
    output logic             level_out
);
    level_state_t state_q, state_d;
    logic         rise_hit;
    logic         fall_hit;
    logic         raw_high;

    assign rise_hit = run && rise_valid && (rise_pos == pos);
    assign fall_hit = run && fall_valid && (fall_pos == pos);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LV_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_LOW:  if (rise_hit && !fall_hit) state_d = LV_HIGH;
            LV_HIGH: if (fall_hit && !rise_hit) state_d = LV_LOW;
            default: state_d = LV_LOW;
        endcase
    end

    always_comb begin
        raw_high  = (state_q == LV_HIGH);
        level_out = raw_high ^ invert;
    end

    AST_RISE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_hit && !fall_hit) |=> raw_high); // R5
    AST_FALL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_hit && !rise_hit) |=> !raw_high); // R6
    AST_EQUAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_hit == fall_hit) |=> $stable(raw_high)); // R7

endmodule

// File: rtl/sample_strobe.sv
module sample_strobe
    import edge_gen_pkg::*;
#(
    parameter int unsigned POS_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [POS_W-1:0] pos,
    input  logic             loc_valid,
    input  logic [POS_W-1:0] loc_pos,
    output logic             strobe
);
    strobe_state_t state_q, state_d;
    logic          hit;

    assign hit = run && loc_valid && (loc_pos == pos);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SS_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SS_WAIT: if (hit) state_d = SS_FIRE;
            SS_FIRE: state_d = SS_WAIT;
            default: state_d = SS_WAIT;
        endcase
    end

    always_comb begin
        strobe = (state_q == SS_FIRE);
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R11
    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $past(hit)); // R11

endmodule

// File: rtl/subpixel_edge_gen.sv
module subpixel_edge_gen
    import edge_gen_pkg::*;
#(
    parameter int unsigned POSITIONS = 48,
    parameter int unsigned CODE_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_ref,
    input  logic [CODE_W-1:0] rg_rise_code,
    input  logic [CODE_W-1:0] rg_fall_code,
    input  logic              rg_invert,
    input  logic [CODE_W-1:0] hl_rise_code,
    input  logic [CODE_W-1:0] hl_fall_code,
    input  logic              hl_invert,
    input  logic [CODE_W-1:0] h_rise_code,
    input  logic [CODE_W-1:0] h_fall_code,
    input  logic              h_invert,
    input  logic [CODE_W-1:0] shp_code,
    input  logic [CODE_W-1:0] shd_code,
    input  logic              hblank,
    input  logic              hblank_level,
    output logic              rg_out,
    output logic              hl_out,
    output logic              h13_out,
    output logic              h24_out,
    output logic              shp_strobe,
    output logic              shd_strobe
);
    localparam int unsigned POS_W      = $clog2(POSITIONS);
    localparam int unsigned QUAD_STEP  = POSITIONS / 4;
    localparam int unsigned NUM_CHAN   = 3;
    localparam int unsigned NUM_STROBE = 2;
    localparam int unsigned NUM_CODES  = 2 * NUM_CHAN + NUM_STROBE;

    logic [POS_W-1:0]  cur_pos;
    logic              running;

    logic [CODE_W-1:0] code_arr  [NUM_CODES];
    logic              valid_arr [NUM_CODES];
    logic [POS_W-1:0]  pos_arr   [NUM_CODES];
    logic              inv_arr   [NUM_CHAN];
    logic              lvl_arr   [NUM_CHAN];
    logic              stb_arr   [NUM_STROBE];
    logic              h_chan;

    // Code order: channel c uses 2c (rise) and 2c+1 (fall); strobes follow
    always_comb begin
        code_arr[0] = rg_rise_code;
        code_arr[1] = rg_fall_code;
        code_arr[2] = hl_rise_code;
        code_arr[3] = hl_fall_code;
        code_arr[4] = h_rise_code;
        code_arr[5] = h_fall_code;
        code_arr[6] = shp_code;
        code_arr[7] = shd_code;
        inv_arr[0]  = rg_invert;
        inv_arr[1]  = hl_invert;
        inv_arr[2]  = h_invert;
    end

    pixel_pos_counter #(
        .POSITIONS (POSITIONS),
        .POS_W     (POS_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_ref (pix_ref),
        .pos     (cur_pos),
        .running (running)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_CODES; gi++) begin : g_dec
            edge_code_decode #(
                .CODE_W    (CODE_W),
                .POS_W     (POS_W),
                .QUAD_STEP (QUAD_STEP)
            ) u_dec (
                .code  (code_arr[gi]),
                .valid (valid_arr[gi]),
                .pos   (pos_arr[gi])
            );
        end

        for (gi = 0; gi < NUM_CHAN; gi++) begin : g_chan
            edge_channel #(
                .POS_W (POS_W)
            ) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .run        (running),
                .pos        (cur_pos),
                .rise_valid (valid_arr[2*gi]),
                .rise_pos   (pos_arr[2*gi]),
                .fall_valid (valid_arr[2*gi+1]),
                .fall_pos   (pos_arr[2*gi+1]),
                .invert     (inv_arr[gi]),
                .level_out  (lvl_arr[gi])
            );
        end

        for (gi = 0; gi < NUM_STROBE; gi++) begin : g_strobe
            sample_strobe #(
                .POS_W (POS_W)
            ) u_strobe (
                .clk       (clk),
                .rst_n     (rst_n),
                .run       (running),
                .pos       (cur_pos),
                .loc_valid (valid_arr[2*NUM_CHAN+gi]),
                .loc_pos   (pos_arr[2*NUM_CHAN+gi]),
                .strobe    (stb_arr[gi])
            );
        end
    endgenerate

    always_comb begin
        h_chan     = lvl_arr[2];
        rg_out     = lvl_arr[0];
        hl_out     = lvl_arr[1];
        h13_out    = hblank ? hblank_level : h_chan;
        h24_out    = ~h13_out;
        shp_strobe = stb_arr[0];
        shd_strobe = stb_arr[1];
    end

    AST_STROBES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !(shp_strobe || shd_strobe)); // R1
    AST_BLANK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank && $past(hblank) && $stable(hblank_level)) |-> $stable(h13_out)); // R10

endmodule

// File: tb/subpixel_edge_gen_test.sv
`timescale 1ns/1ps
module subpixel_edge_gen_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       pix_ref;
    logic [5:0] rg_rise_code, rg_fall_code, hl_rise_code, hl_fall_code;
    logic [5:0] h_rise_code, h_fall_code, shp_code, shd_code;
    logic       rg_invert, hl_invert, h_invert, hblank, hblank_level;
    logic       rg_out, hl_out, h13_out, h24_out, shp_strobe, shd_strobe;

    int n_checks = 0;
    int n_fails  = 0;
    int ofs      = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    subpixel_edge_gen uut (
        .clk(clk), .rst_n(rst_n), .pix_ref(pix_ref),
        .rg_rise_code(rg_rise_code), .rg_fall_code(rg_fall_code), .rg_invert(rg_invert),
        .hl_rise_code(hl_rise_code), .hl_fall_code(hl_fall_code), .hl_invert(hl_invert),
        .h_rise_code(h_rise_code), .h_fall_code(h_fall_code), .h_invert(h_invert),
        .shp_code(shp_code), .shd_code(shd_code),
        .hblank(hblank), .hblank_level(hblank_level),
        .rg_out(rg_out), .hl_out(hl_out), .h13_out(h13_out), .h24_out(h24_out),
        .shp_strobe(shp_strobe), .shd_strobe(shd_strobe)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s at offset %0d: actual %b expected %b", req, ofs, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pix_ref = 1'b0;
        rg_rise_code = '0; rg_fall_code = '0; rg_invert = 1'b0;
        hl_rise_code = '0; hl_fall_code = '0; hl_invert = 1'b0;
        h_rise_code  = '0; h_fall_code  = '0; h_invert  = 1'b0;
        shp_code = 6'd12; shd_code = 6'd12;
        hblank = 1'b0; hblank_level = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive a one-cycle reference pulse; returns at the negedge after E0 (offset 0)
    task automatic sync_ref();
        pix_ref = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pix_ref = 1'b0;
        ofs = 0;
    endtask

    task automatic go(input int n);
        while (ofs < n) begin
            @(posedge clk);
            @(negedge clk);
            ofs++;
        end
    endtask

    task automatic test_reset();
        int shp_seen = 0;
        do_reset();
        rg_rise_code = 6'd2; rg_fall_code = 6'd16; shp_code = 6'd3;
        ofs = 0;
        chk("R1 rg reset", rg_out, 1'b0);
        chk("R1 h13 reset", h13_out, 1'b0);
        chk("R1 h24 reset", h24_out, 1'b1);
        for (int i = 0; i < 60; i++) begin
            go(ofs + 1);
            if (shp_strobe) shp_seen++;
        end
        chk("R1 rg idle", rg_out, 1'b0);
        chk_int("R1 shp idle pulses", shp_seen, 0);
        hl_invert = 1'b1;
        go(ofs + 1);
        chk("R1 hl inverted idle", hl_out, 1'b1);
    endtask

    task automatic test_basic();
        do_reset();
        rg_rise_code = 6'd2; rg_fall_code = 6'd16;   // slots 2 and 12
        sync_ref();
        go(2);  chk("R5 rg before rise", rg_out, 1'b0);
        go(3);  chk("R5 rg after rise", rg_out, 1'b1);
        go(12); chk("R6 rg before fall", rg_out, 1'b1);
        go(13); chk("R6 rg after fall", rg_out, 1'b0);
    endtask

    task automatic test_quadrant();
        do_reset();
        h_rise_code = 6'd37; h_fall_code = 6'd51;    // slots 29 and 39
        sync_ref();
        go(29); chk("R3 h13 before slot 29", h13_out, 1'b0);
        go(30); chk("R3 h13 at slot 29", h13_out, 1'b1);
                chk("R9 h24 inverse", h24_out, 1'b0);
        go(39); chk("R3 h13 before slot 39", h13_out, 1'b1);
        go(40); chk("R3 h13 at slot 39", h13_out, 1'b0);
                chk("R9 h24 inverse low", h24_out, 1'b1);
    endtask

    task automatic test_invalid();
        int seen_high = 0;
        int seen_low  = 0;
        do_reset();
        hl_rise_code = 6'd12; hl_fall_code = 6'd30;  // both offsets >= 12
        sync_ref();
        for (int i = 1; i <= 50; i++) begin go(i); if (hl_out) seen_high++; end
        chk_int("R4 invalid rise never fires", seen_high, 0);
        hl_rise_code = 6'd5;
        go(ofs + 48);
        chk("R4 valid rise sets level", hl_out, 1'b1);
        for (int i = 0; i < 50; i++) begin go(ofs + 1); if (!hl_out) seen_low++; end
        chk_int("R4 invalid fall never fires", seen_low, 0);
    endtask

    task automatic test_equal();
        int seen = 0;
        do_reset();
        rg_rise_code = 6'd20; rg_fall_code = 6'd20;
        sync_ref();
        for (int i = 1; i <= 50; i++) begin go(i); if (rg_out) seen++; end
        chk_int("R7 equal slots hold low", seen, 0);
        do_reset();
        rg_rise_code = 6'd4; rg_fall_code = 6'd52;   // slots 4 and 40
        sync_ref();
        go(10); chk("R7 rg high before change", rg_out, 1'b1);
        rg_rise_code = 6'd33; rg_fall_code = 6'd33; // both slot 25
        seen = 0;
        for (int i = 11; i <= 70; i++) begin go(i); if (!rg_out) seen++; end
        chk_int("R7 equal slots hold high", seen, 0);
    endtask

    task automatic test_polarity();
        do_reset();
        hl_rise_code = 6'd3; hl_fall_code = 6'd8; hl_invert = 1'b1;
        sync_ref();
        chk("R8 inverted at start", hl_out, 1'b1);
        go(4); chk("R8 inverted after rise", hl_out, 1'b0);
        go(9); chk("R8 inverted after fall", hl_out, 1'b1);
    endtask

    task automatic test_blank();
        do_reset();
        h_rise_code = 6'd0; h_fall_code = 6'd32;     // slots 0 and 24
        sync_ref();
        hblank = 1'b1; hblank_level = 1'b0;
        go(10); chk("R10 blank low over high level", h13_out, 1'b0);
                chk("R9 h24 during blank", h24_out, 1'b1);
        hblank_level = 1'b1;
        go(30); chk("R10 blank high over low level", h13_out, 1'b1);
                chk("R9 h24 opposite blank", h24_out, 1'b0);
        hblank = 1'b0;
        go(31); chk("R10 released follows channel", h13_out, 1'b0);
        go(49); chk("R10 released rise", h13_out, 1'b1);
    endtask

    task automatic test_strobe();
        int shp_n = 0;
        int shd_n = 0;
        do_reset();
        shp_code = 6'd17; shd_code = 6'd0;           // slots 13 and 0
        sync_ref();
        go(1);  chk("R11 shd at slot 0", shd_strobe, 1'b1);
        go(13); chk("R11 shp before", shp_strobe, 1'b0);
        go(14); chk("R11 shp fires", shp_strobe, 1'b1);
        go(15); chk("R11 shp one cycle", shp_strobe, 1'b0);
        do_reset();
        shp_code = 6'd17; shd_code = 6'd0;
        sync_ref();
        for (int i = 1; i <= 48; i++) begin
            go(i);
            if (shp_strobe) shp_n++;
            if (shd_strobe) shd_n++;
        end
        chk_int("R11 shp pulses per period", shp_n, 1);
        chk_int("R11 shd pulses per period", shd_n, 1);
        go(49); chk("R11 shd next period", shd_strobe, 1'b1);
    endtask

    task automatic test_wrap();
        do_reset();
        rg_rise_code = 6'd59; rg_fall_code = 6'd0;   // slots 47 and 0
        sync_ref();
        go(47); chk("R2 rg before slot 47", rg_out, 1'b0);
        go(48); chk("R2 rg at slot 47", rg_out, 1'b1);
        go(49); chk("R2 rg after wrap to 0", rg_out, 1'b0);
    endtask

    task automatic test_resync();
        do_reset();
        rg_rise_code = 6'd5; rg_fall_code = 6'd6;
        sync_ref();
        go(20);
        sync_ref();
        go(5); chk("R12 before new slot 5", rg_out, 1'b0);
        go(6); chk("R12 new slot 5 rise", rg_out, 1'b1);
        go(7); chk("R12 new slot 6 fall", rg_out, 1'b0);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        test_reset();
        test_basic();
        test_quadrant();
        test_invalid();
        test_equal();
        test_polarity();
        test_blank();
        test_strobe();
        test_wrap();
        test_resync();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule